// File: doc/BRIEF.md
# Prefetch Request Queue

This block holds pending hardware prefetch requests beside a cache. An external address generator offers candidate line addresses one at a time. Each candidate carries a delay that is added to the timestamp of the latest accepted demand miss, which gives the candidate its ready time. For every candidate the block asks the cache, over a shared lookup port, whether the line is already cached or already outstanding in the miss queue. Candidates found in the miss queue, or found among the queue's own entries, are dropped. The survivors are appended in arrival order. When the queue is full, the oldest entry is discarded to make room.

A demand miss deletes any queued entry for the same line. With the serial-squash option, a demand miss also discards entries from the tail while their ready time is not earlier than the miss time. A downstream port requests a prefetch with a one-cycle pulse. The block pops entries from the head and, with the check-on-push option off, asks the cache about each popped line. Lines already cached are skipped, and the first line not cached is issued. A bus-request flag stays high while the queue holds entries. Eight event counters record what happened to candidates and entries.

Top module: `pfetch_queue`

## Requirements
- R1: A demand miss with `miss_uncache`=1, or with `miss_ifetch`=1 while the data-only option is set (the default), is ignored. It deletes no entry and squashes no entry. Neither the removal counter (`ev_counts` slot 5) nor the squash counter (slot 6) changes.
- R2: All address comparisons and all issued addresses use the line address, formed by clearing the low log2(`LINE_BYTES`) address bits. `lk_addr` and `iss_addr` are always line aligned.
- R3: A qualifying demand miss deletes the queued entry whose line equals the miss line, and adds 1 to slot 5. The other entries keep their order.
- R4: With serial squash enabled (the default), a qualifying miss discards entries from the tail while each tail entry's ready time is greater than or equal to `miss_time`. It stops at the first tail entry with an earlier ready time. Slot 6 grows by the number of entries discarded.
- R5: A candidate's ready time is the `miss_time` of the latest qualifying miss plus `cand_delay`, taken modulo 2^`TW`. This time is 0 before any miss has been accepted.
- R6: A candidate whose lookup returns `lk_in_mshr`=1 is not inserted, and the miss-queue-hit counter (slot 2) adds 1.
- R7: A candidate whose line is already queued is not inserted, and the own-queue-hit counter (slot 3) adds 1. With check-on-push off, a candidate whose lookup returns `lk_in_cache`=1 is still inserted, and the cache-hit counter (slot 1) does not change.
- R8: Inserting into a queue that already holds `DEPTH` entries first discards the head entry and adds 1 to the eviction counter (slot 4). The new entry is then appended at the tail.
- R9: An issue request pops entries in insertion order. With check-on-push off, each popped head line is looked up, and a line reported as cached is discarded. The first line reported as not cached is issued: `iss_done`=1 and `iss_valid`=1 with its address, and the issued counter (slot 7) adds 1.
- R10: An issue request finds nothing to issue when the queue is empty, or when every remaining line is reported cached. It then ends with `iss_done`=1 and `iss_valid`=0, and slot 7 does not change.
- R11: `bus_req` is low after reset. It goes high when an entry is appended, and goes low as soon as the queue becomes empty, whether through issue, removal or squash.
- R12: While a lookup is outstanding (`lk_req`=1), `cand_ready` is low and no further candidate is accepted. The identified counter (slot 0) adds 1 for every accepted candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand miss event |
| miss_ready | output | 1 | Miss event accepted this cycle |
| miss_addr | input | AW | Demand miss byte address |
| miss_time | input | TW | Demand miss timestamp |
| miss_uncache | input | 1 | Miss is to uncacheable space |
| miss_ifetch | input | 1 | Miss comes from an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | AW | Candidate byte address |
| cand_delay | input | DW | Candidate delay added to the miss time |
| lk_req | output | 1 | Lookup outstanding |
| lk_addr | output | AW | Line address to look up |
| lk_ack | input | 1 | Lookup answer valid |
| lk_in_cache | input | 1 | Line present in the cache |
| lk_in_mshr | input | 1 | Line present in the miss queue |
| iss_req | input | 1 | Issue request pulse |
| iss_ready | output | 1 | Issue request accepted this cycle |
| iss_done | output | 1 | Issue request finished (one cycle) |
| iss_valid | output | 1 | `iss_addr` carries an issued prefetch |
| iss_addr | output | AW | Issued line address |
| bus_req | output | 1 | Prefetch bus request |
| ev_counts | output | 8 x CW | Event counters, slots 0 to 7 as named in the requirements |

## Verification
Every result is registered. The effect of an accepted miss or issue request, and the entry into the lookup wait after an accepted candidate, appear one cycle after the accepting edge. The outcome of a lookup, whether the candidate is inserted or dropped, an entry is popped, or the issue ends, appears one cycle after the edge on which `lk_ack` is high. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each read comes exactly one register stage after the stimulus. Issue tasks keep answering lookups until `iss_done` is seen, which lets the multi-cycle skip sequence settle before its result is compared.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAND  = 2'd1,
        ST_ISSUE = 2'd2
    } pfq_state_e;

    localparam int NEV       = 8;
    localparam int EV_IDENT  = 0;
    localparam int EV_CACHE  = 1;
    localparam int EV_MSHR   = 2;
    localparam int EV_DUP    = 3;
    localparam int EV_EVICT  = 4;
    localparam int EV_REMOVE = 5;
    localparam int EV_SQUASH = 6;
    localparam int EV_ISSUED = 7;
endpackage

// File: rtl/pfq_match.sv
module pfq_match #(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0][AW-1:0] line_i,
    input  logic [DEPTH-1:0]         vld_i,
    input  logic [AW-1:0]            key_i,
    output logic [DEPTH-1:0]         hit_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_o[g] = vld_i[g] && (line_i[g] == key_i);
    end
endmodule

// File: rtl/pfq_prune.sv
module pfq_prune #(
    parameter int TW    = 16,
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]         vld_i,
    input  logic [DEPTH-1:0]         hit_i,
    input  logic [DEPTH-1:0][TW-1:0] rtime_i,
    input  logic [TW-1:0]            mtime_i,
    input  logic                     squash_en_i,
    output logic [DEPTH-1:0]         keep_o,
    output logic                     removed_o,
    output logic [CNTW-1:0]          squashed_o
);
    logic tail_run;

    always_comb begin
        tail_run   = 1'b1;
        removed_o  = 1'b0;
        squashed_o = '0;
        keep_o     = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_i[i]) begin
                if (hit_i[i]) begin
                    removed_o = 1'b1;
                end else if (squash_en_i && tail_run && (rtime_i[i] >= mtime_i)) begin
                    squashed_o = squashed_o + 1'b1;
                end else begin
                    tail_run  = 1'b0;
                    keep_o[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pfq_compact.sv
module pfq_compact #(
    parameter int AW    = 32,
    parameter int TW    = 16,
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]         keep_i,
    input  logic [DEPTH-1:0][AW-1:0] line_i,
    input  logic [DEPTH-1:0][TW-1:0] rtime_i,
    output logic [DEPTH-1:0][AW-1:0] line_o,
    output logic [DEPTH-1:0][TW-1:0] rtime_o,
    output logic [CNTW-1:0]          count_o
);
    logic [CNTW-1:0] pos;

    always_comb begin
        pos     = '0;
        line_o  = '0;
        rtime_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep_i[i]) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (pos == CNTW'(k)) begin
                        line_o[k]  = line_i[i];
                        rtime_o[k] = rtime_i[i];
                    end
                end
                pos = pos + 1'b1;
            end
        end
        count_o = pos;
    end
endmodule

// File: rtl/pfetch_queue.sv
module pfetch_queue
    import pfq_pkg::*;
#(
    parameter int AW            = 32,
    parameter int LINE_BYTES    = 64,
    parameter int DEPTH         = 8,
    parameter int TW            = 16,
    parameter int DW            = 8,
    parameter int CW            = 16,
    parameter bit CHECK_ON_PUSH = 1'b0,
    parameter bit SERIAL_SQUASH = 1'b1,
    parameter bit DATA_ONLY     = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   miss_valid,
    output logic                   miss_ready,
    input  logic [AW-1:0]          miss_addr,
    input  logic [TW-1:0]          miss_time,
    input  logic                   miss_uncache,
    input  logic                   miss_ifetch,
    input  logic                   cand_valid,
    output logic                   cand_ready,
    input  logic [AW-1:0]          cand_addr,
    input  logic [DW-1:0]          cand_delay,
    output logic                   lk_req,
    output logic [AW-1:0]          lk_addr,
    input  logic                   lk_ack,
    input  logic                   lk_in_cache,
    input  logic                   lk_in_mshr,
    input  logic                   iss_req,
    output logic                   iss_ready,
    output logic                   iss_done,
    output logic                   iss_valid,
    output logic [AW-1:0]          iss_addr,
    output logic                   bus_req,
    output logic [NEV-1:0][CW-1:0] ev_counts
);
    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LMASK = {{(AW - OFFW){1'b1}}, {OFFW{1'b0}}};

    typedef struct packed {
        pfq_state_e                st;
        logic [DEPTH-1:0][AW-1:0]  line;
        logic [DEPTH-1:0][TW-1:0]  rtime;
        logic [CNTW-1:0]           occ;
        logic [TW-1:0]             mtime;
        logic [AW-1:0]             pend_line;
        logic [TW-1:0]             pend_time;
        logic                      bus;
        logic                      done;
        logic                      ivalid;
        logic [AW-1:0]             iaddr;
        logic [NEV-1:0][CW-1:0]    cnt;
    } pfq_regs_t;

    pfq_regs_t s_q, s_d;

    logic [DEPTH-1:0]         vld;
    logic [DEPTH-1:0]         miss_hit;
    logic [DEPTH-1:0]         pend_hit;
    logic [DEPTH-1:0]         prune_keep;
    logic                     prune_rm;
    logic [CNTW-1:0]          prune_sq;
    logic [DEPTH-1:0]         keep_sel;
    logic [DEPTH-1:0][AW-1:0] cmp_line;
    logic [DEPTH-1:0][TW-1:0] cmp_rtime;
    logic [CNTW-1:0]          cmp_cnt;
    logic [AW-1:0]            miss_line;
    logic [AW-1:0]            cand_line;
    logic                     miss_qual;
    logic                     append;
    logic [CNTW-1:0]          occ_q;

    assign miss_line = miss_addr & LMASK;
    assign cand_line = cand_addr & LMASK;
    assign miss_qual = !miss_uncache && !(DATA_ONLY && miss_ifetch);
    assign occ_q     = s_q.occ;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld[i] = (i < int'(s_q.occ));
        end
    end

    pfq_match #(.AW(AW), .DEPTH(DEPTH)) u_miss_match (
        .line_i (s_q.line),
        .vld_i  (vld),
        .key_i  (miss_line),
        .hit_o  (miss_hit)
    );

    pfq_match #(.AW(AW), .DEPTH(DEPTH)) u_pend_match (
        .line_i (s_q.line),
        .vld_i  (vld),
        .key_i  (s_q.pend_line),
        .hit_o  (pend_hit)
    );

    pfq_prune #(.TW(TW), .DEPTH(DEPTH)) u_prune (
        .vld_i       (vld),
        .hit_i       (miss_hit),
        .rtime_i     (s_q.rtime),
        .mtime_i     (miss_time),
        .squash_en_i (SERIAL_SQUASH),
        .keep_o      (prune_keep),
        .removed_o   (prune_rm),
        .squashed_o  (prune_sq)
    );

    pfq_compact #(.AW(AW), .TW(TW), .DEPTH(DEPTH)) u_compact (
        .keep_i  (keep_sel),
        .line_i  (s_q.line),
        .rtime_i (s_q.rtime),
        .line_o  (cmp_line),
        .rtime_o (cmp_rtime),
        .count_o (cmp_cnt)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.ivalid = 1'b0;
        keep_sel   = vld;
        append     = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (miss_valid) begin
                    if (miss_qual) begin
                        keep_sel              = prune_keep;
                        s_d.mtime             = miss_time;
                        s_d.cnt[EV_REMOVE]    = s_q.cnt[EV_REMOVE] + CW'(prune_rm);
                        s_d.cnt[EV_SQUASH]    = s_q.cnt[EV_SQUASH] + CW'(prune_sq);
                    end
                end else if (cand_valid) begin
                    s_d.pend_line      = cand_line;
                    s_d.pend_time      = s_q.mtime + TW'(cand_delay);
                    s_d.cnt[EV_IDENT]  = s_q.cnt[EV_IDENT] + 1'b1;
                    s_d.st             = ST_CAND;
                end else if (iss_req) begin
                    if (s_q.occ == '0) begin
                        s_d.done = 1'b1;
                    end else if (CHECK_ON_PUSH) begin
                        keep_sel           = vld & ~DEPTH'(1);
                        s_d.done           = 1'b1;
                        s_d.ivalid         = 1'b1;
                        s_d.iaddr          = s_q.line[0];
                        s_d.cnt[EV_ISSUED] = s_q.cnt[EV_ISSUED] + 1'b1;
                    end else begin
                        s_d.st = ST_ISSUE;
                    end
                end
            end
            ST_CAND: begin
                if (lk_ack) begin
                    s_d.st = ST_IDLE;
                    if (CHECK_ON_PUSH && lk_in_cache) begin
                        s_d.cnt[EV_CACHE] = s_q.cnt[EV_CACHE] + 1'b1;
                    end else if (lk_in_mshr) begin
                        s_d.cnt[EV_MSHR] = s_q.cnt[EV_MSHR] + 1'b1;
                    end else if (|pend_hit) begin
                        s_d.cnt[EV_DUP] = s_q.cnt[EV_DUP] + 1'b1;
                    end else begin
                        append = 1'b1;
                        if (int'(s_q.occ) == DEPTH) begin
                            keep_sel          = vld & ~DEPTH'(1);
                            s_d.cnt[EV_EVICT] = s_q.cnt[EV_EVICT] + 1'b1;
                        end
                    end
                end
            end
            ST_ISSUE: begin
                if (lk_ack) begin
                    keep_sel = vld & ~DEPTH'(1);
                    if (lk_in_cache) begin
                        if (s_q.occ == CNTW'(1)) begin
                            s_d.done = 1'b1;
                            s_d.st   = ST_IDLE;
                        end
                    end else begin
                        s_d.done           = 1'b1;
                        s_d.ivalid         = 1'b1;
                        s_d.iaddr          = s_q.line[0];
                        s_d.cnt[EV_ISSUED] = s_q.cnt[EV_ISSUED] + 1'b1;
                        s_d.st             = ST_IDLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        s_d.line  = cmp_line;
        s_d.rtime = cmp_rtime;
        s_d.occ   = cmp_cnt;
        if (append) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (cmp_cnt == CNTW'(k)) begin
                    s_d.line[k]  = s_q.pend_line;
                    s_d.rtime[k] = s_q.pend_time;
                end
            end
            s_d.occ = cmp_cnt + 1'b1;
            s_d.bus = 1'b1;
        end else if (cmp_cnt == '0) begin
            s_d.bus = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign miss_ready = (s_q.st == ST_IDLE);
    assign cand_ready = (s_q.st == ST_IDLE) && !miss_valid;
    assign iss_ready  = (s_q.st == ST_IDLE) && !miss_valid && !cand_valid;
    assign lk_req     = (s_q.st != ST_IDLE);
    assign lk_addr    = (s_q.st == ST_CAND) ? s_q.pend_line : s_q.line[0];
    assign iss_done   = s_q.done;
    assign iss_valid  = s_q.ivalid;
    assign iss_addr   = s_q.iaddr;
    assign bus_req    = s_q.bus;
    assign ev_counts  = s_q.cnt;
endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
    parameter int DEPTH = 8,
    parameter int CNTW  = 4,
    parameter int CW    = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            miss_valid,
    input logic            miss_ready,
    input logic            miss_uncache,
    input logic            cand_ready,
    input logic            lk_req,
    input logic            iss_valid,
    input logic            iss_done,
    input logic            bus_req,
    input logic [CNTW-1:0] occ,
    input logic [CW-1:0]   ident
);
    AST_IGNORED_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && miss_uncache) |=> (occ == $past(occ))); // R1

    AST_OCC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH); // R8

    AST_ISSUE_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((int'(occ) + 1) == int'($past(occ)))); // R9

    AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> iss_done); // R10

    AST_BUS_WHILE_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req == (occ != '0)); // R11

    AST_NO_CAND_IN_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> !cand_ready); // R12

    AST_IDENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(ident - $past(ident)) <= CW'(1)); // R12
endmodule

bind pfetch_queue pfq_chk #(.DEPTH(DEPTH), .CNTW(CNTW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .miss_uncache (miss_uncache),
    .cand_ready   (cand_ready),
    .lk_req       (lk_req),
    .iss_valid    (iss_valid),
    .iss_done     (iss_done),
    .bus_req      (bus_req),
    .occ          (occ_q),
    .ident        (ev_counts[pfq_pkg::EV_IDENT])
);

// File: tb/sim_pfetch_queue.sv
`timescale 1ns/1ps
module sim_pfetch_queue;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             miss_valid = 1'b0, miss_uncache = 1'b0, miss_ifetch = 1'b0;
    logic [31:0]      miss_addr = '0;
    logic [15:0]      miss_time = '0;
    logic             miss_ready;
    logic             cand_valid = 1'b0;
    logic [31:0]      cand_addr = '0;
    logic [7:0]       cand_delay = '0;
    logic             cand_ready;
    logic             lk_req, lk_ack = 1'b0, lk_in_cache = 1'b0, lk_in_mshr = 1'b0;
    logic [31:0]      lk_addr;
    logic             iss_req = 1'b0, iss_ready, iss_done, iss_valid;
    logic [31:0]      iss_addr;
    logic             bus_req;
    logic [7:0][15:0] evc;

    int checks = 0;
    int errors = 0;
    int exp_cnt [8];

    always #2 clk = ~clk;

    pfetch_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .miss_time(miss_time), .miss_uncache(miss_uncache), .miss_ifetch(miss_ifetch),
        .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
        .cand_delay(cand_delay),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_ack(lk_ack),
        .lk_in_cache(lk_in_cache), .lk_in_mshr(lk_in_mshr),
        .iss_req(iss_req), .iss_ready(iss_ready), .iss_done(iss_done),
        .iss_valid(iss_valid), .iss_addr(iss_addr),
        .bus_req(bus_req), .ev_counts(evc)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic chk_counts(input string tag);
        for (int i = 0; i < 8; i++) begin
            chk($sformatf("%s slot%0d", tag, i), 32'(evc[i]), 32'(exp_cnt[i]));
        end
    endtask

    task automatic do_miss(input logic [31:0] a, input logic [15:0] t,
                           input logic unc, input logic ifet);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a; miss_time = t;
        miss_uncache = unc; miss_ifetch = ifet;
        @(negedge clk);
        miss_valid = 1'b0; miss_uncache = 1'b0; miss_ifetch = 1'b0;
    endtask

    task automatic do_cand(input logic [31:0] a, input logic [7:0] d,
                           input logic c, input logic m);
        @(negedge clk);
        cand_valid = 1'b1; cand_addr = a; cand_delay = d;
        @(negedge clk);
        cand_valid = 1'b0;
        lk_ack = 1'b1; lk_in_cache = c; lk_in_mshr = m;
        @(negedge clk);
        lk_ack = 1'b0; lk_in_cache = 1'b0; lk_in_mshr = 1'b0;
        exp_cnt[0]++;
    endtask

    task automatic do_issue(input logic [7:0] hits, output logic v, output logic [31:0] a);
        int n;
        n = 0;
        @(negedge clk);
        iss_req = 1'b1;
        @(negedge clk);
        iss_req = 1'b0;
        while (!iss_done && lk_req && n < 8) begin
            lk_ack = 1'b1; lk_in_cache = hits[n];
            n++;
            @(negedge clk);
            lk_ack = 1'b0; lk_in_cache = 1'b0;
        end
        v = iss_valid;
        a = iss_addr;
        chk("issue done", 32'(iss_done), 32'd1);
    endtask

    task automatic expect_issue(input string tag, input logic [7:0] hits,
                                input logic [31:0] exp_a);
        logic v;
        logic [31:0] a;
        do_issue(hits, v, a);
        chk({tag, " valid"}, 32'(v), 32'd1);
        chk({tag, " addr"}, a, exp_a);
        exp_cnt[7]++;
    endtask

    task automatic expect_nothing(input string tag, input logic [7:0] hits);
        logic v;
        logic [31:0] a;
        do_issue(hits, v, a);
        chk({tag, " valid"}, 32'(v), 32'd0);
    endtask

    task automatic t_reset;
        chk("R11 bus after reset", 32'(bus_req), 32'd0);
        chk("R12 cand_ready after reset", 32'(cand_ready), 32'd1);
        chk("R12 lk_req after reset", 32'(lk_req), 32'd0);
        chk_counts("reset");
    endtask

    task automatic t_basic;
        do_cand(32'h0000_1000, 8'd0, 1'b0, 1'b0);
        chk("R11 bus after append", 32'(bus_req), 32'd1);
        do_cand(32'h0000_2047, 8'd0, 1'b0, 1'b0);
        chk_counts("R12 ident");
        expect_issue("R9 first in order", 8'h00, 32'h0000_1000);
        expect_issue("R2 aligned issue", 8'h00, 32'h0000_2040);
        chk("R11 bus after drain", 32'(bus_req), 32'd0);
        chk_counts("R9 issued");
    endtask

    task automatic t_mshr;
        do_cand(32'h0000_3000, 8'd0, 1'b0, 1'b1);
        exp_cnt[2]++;
        chk_counts("R6 mshr drop");
        chk("R6 bus stays low", 32'(bus_req), 32'd0);
        expect_nothing("R10 empty issue", 8'h00);
    endtask

    task automatic t_dup;
        do_cand(32'h0000_4000, 8'd0, 1'b0, 1'b0);
        do_cand(32'h0000_4010, 8'd0, 1'b0, 1'b0);
        exp_cnt[3]++;
        do_cand(32'h0000_5000, 8'd0, 1'b1, 1'b0);
        chk_counts("R7 dup and cache");
        expect_issue("R7 first", 8'h00, 32'h0000_4000);
        expect_issue("R7 cached cand kept", 8'h00, 32'h0000_5000);
        chk("R7 bus empty", 32'(bus_req), 32'd0);
    endtask

    task automatic t_ignored;
        do_cand(32'h0000_6000, 8'd0, 1'b0, 1'b0);
        do_miss(32'h0000_6008, 16'd0, 1'b1, 1'b0);
        do_miss(32'h0000_6000, 16'd0, 1'b0, 1'b1);
        chk_counts("R1 ignored misses");
        chk("R1 bus kept", 32'(bus_req), 32'd1);
        expect_issue("R1 entry survives", 8'h00, 32'h0000_6000);
    endtask

    task automatic t_remove;
        do_miss(32'h0000_0100, 16'd100, 1'b0, 1'b0);
        do_cand(32'h0000_7000, 8'd5, 1'b0, 1'b0);
        do_cand(32'h0000_7040, 8'd5, 1'b0, 1'b0);
        do_miss(32'h0000_7044, 16'd200, 1'b0, 1'b0);
        exp_cnt[5]++;
        chk_counts("R3 removal");
        expect_issue("R3 other kept", 8'h00, 32'h0000_7000);
        chk("R3 bus empty", 32'(bus_req), 32'd0);
    endtask

    task automatic t_squash;
        do_miss(32'h0000_0140, 16'd300, 1'b0, 1'b0);
        do_cand(32'h0000_8000, 8'd1, 1'b0, 1'b0);
        do_cand(32'h0000_8040, 8'd5, 1'b0, 1'b0);
        do_cand(32'h0000_8080, 8'd9, 1'b0, 1'b0);
        do_miss(32'h0000_0180, 16'd305, 1'b0, 1'b0);
        exp_cnt[6] += 2;
        chk_counts("R4 R5 squash two");
        chk("R4 bus kept", 32'(bus_req), 32'd1);
        expect_issue("R4 earliest kept", 8'h00, 32'h0000_8000);
        chk("R4 bus empty", 32'(bus_req), 32'd0);
        do_cand(32'h0000_9000, 8'd1, 1'b0, 1'b0);
        chk("R11 bus before squash", 32'(bus_req), 32'd1);
        do_miss(32'h0000_01C0, 16'd306, 1'b0, 1'b0);
        exp_cnt[6]++;
        chk_counts("R5 equal time squashed");
        chk("R11 bus low after squash", 32'(bus_req), 32'd0);
        do_cand(32'h0000_A000, 8'd0, 1'b0, 1'b0);
        do_miss(32'h0000_A020, 16'd400, 1'b0, 1'b0);
        exp_cnt[5]++;
        chk_counts("R3 removal not squash");
        chk("R11 bus low after removal", 32'(bus_req), 32'd0);
    endtask

    task automatic t_full;
        do_miss(32'h0000_0200, 16'd1000, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            do_cand(32'h0000_B000 + 32'(i) * 32'h40, 8'd0, 1'b0, 1'b0);
        end
        exp_cnt[4]++;
        chk_counts("R8 eviction");
        for (int i = 1; i < 9; i++) begin
            expect_issue($sformatf("R8 order %0d", i), 8'h00,
                         32'h0000_B000 + 32'(i) * 32'h40);
        end
        chk("R8 bus empty", 32'(bus_req), 32'd0);
    endtask

    task automatic t_skip;
        do_cand(32'h0000_C000, 8'd0, 1'b0, 1'b0);
        do_cand(32'h0000_C040, 8'd0, 1'b0, 1'b0);
        do_cand(32'h0000_C080, 8'd0, 1'b0, 1'b0);
        expect_issue("R9 skip cached", 8'b0000_0011, 32'h0000_C080);
        chk("R9 bus empty", 32'(bus_req), 32'd0);
        do_cand(32'h0000_D000, 8'd0, 1'b0, 1'b0);
        do_cand(32'h0000_D040, 8'd0, 1'b0, 1'b0);
        expect_nothing("R10 all cached", 8'b0000_0011);
        chk("R10 R11 bus low", 32'(bus_req), 32'd0);
        chk_counts("R10 counts");
    endtask

    task automatic t_stall;
        @(negedge clk);
        cand_valid = 1'b1; cand_addr = 32'h0000_E013; cand_delay = 8'd0;
        @(negedge clk);
        cand_valid = 1'b0;
        chk("R12 lookup pending", 32'(lk_req), 32'd1);
        chk("R12 cand stalled", 32'(cand_ready), 32'd0);
        chk("R2 lookup aligned", lk_addr, 32'h0000_E000);
        @(negedge clk);
        @(negedge clk);
        chk("R12 still stalled", 32'(cand_ready), 32'd0);
        lk_ack = 1'b1;
        @(negedge clk);
        lk_ack = 1'b0;
        exp_cnt[0]++;
        chk("R12 ready again", 32'(cand_ready), 32'd1);
        chk("R12 lookup closed", 32'(lk_req), 32'd0);
        expect_issue("R12 stalled cand queued", 8'h00, 32'h0000_E000);
        chk_counts("final");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mshr();
        t_dup();
        t_ignored();
        t_remove();
        t_squash();
        t_full();
        t_skip();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule